// File: doc/BRIEF.md
# Two-Bit Burst Address Sequencer

This block produces the low address bits for a four-beat burst in a synchronous memory interface. Two active-low address strobes, one from a processor and one from a controller, each load the external starting low address on a rising clock edge. After that load, every clock edge on which the active-low advance input is low moves the burst one beat forward. When there is no strobe and no advance, the current position is held. The upper address bits bypass this block.

The block keeps the captured start and a beat index, both as registers. A static order pin selects how the two are combined into the output. In linear order the output is the start plus the beat, wrapping inside the aligned group of four. In interleaved order the output is the start XOR the beat. Both outputs come straight from the registered state, so they change one clock edge after the input that caused the change.

Top module: `burst_addr_seq`

## Requirements
- R1: While rst_n is low, and after reset until the first load, `beat` is 0 and `addr_lo` is 0.
- R2: At a rising edge where `strobe_proc_n` or `strobe_ctrl_n` is low (either one or both), `start_lo` is captured and `beat` becomes 0. The next `addr_lo` then equals the captured start.
- R3: At a rising edge where both strobes are high and `advance_n` is low, `beat` increases by one modulo 4.
- R4: With `mode_interleave` = 0 (linear), `addr_lo` = (start + beat) mod 4.
- R5: With `mode_interleave` = 1 (interleaved), `addr_lo` = start XOR beat.
- R6: At a rising edge where both strobes and `advance_n` are high, `beat` and the captured start keep their values.
- R7: When a strobe and advance are both active at the same edge, the load wins: `beat` becomes 0 and the new start is taken.
- R8: After four advances, `beat` is back at 0 and `addr_lo` is back at the start.
- R9: `start_lo` has no effect at any edge where neither strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strobe_proc_n | input | 1 | Processor address strobe, active low |
| strobe_ctrl_n | input | 1 | Controller address strobe, active low |
| advance_n | input | 1 | Burst advance, active low |
| mode_interleave | input | 1 | Static order select: 0 linear, 1 interleaved |
| start_lo | input | CW | External starting low address |
| addr_lo | output | CW | Generated low address |
| beat | output | CW | Beat index within the burst |

## Verification
Strobes, advance and `start_lo` act at a rising edge, and the resulting `beat` and `addr_lo` are due one edge later, because the outputs come from the registered start and beat. `mode_interleave` acts on `addr_lo` in the same cycle, because it only drives the output mapping. The bench changes its inputs on the falling edge. It then waits through one rising edge and compares the outputs at the next falling edge, so every expected value refers to exactly one registered step. The reset checks are sampled while reset is still held and again on the first cycle after it is released.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
    typedef enum logic {
        ORD_LINEAR = 1'b0,
        ORD_XOR    = 1'b1
    } order_e;

    typedef enum logic [1:0] {
        ACT_HOLD = 2'd0,
        ACT_LOAD = 2'd1,
        ACT_STEP = 2'd2
    } seq_act_e;
endpackage

// File: rtl/burst_beat_ctrl.sv
module burst_beat_ctrl
    import burst_seq_pkg::*;
#(
    parameter int CW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          step,
    input  logic [CW-1:0] start_in,
    output logic [CW-1:0] start_q,
    output logic [CW-1:0] beat_q
);
    typedef struct packed {
        logic [CW-1:0] start;
        logic [CW-1:0] beat;
    } seq_state_t;

    seq_state_t st_d, st_q;
    seq_act_e   act;

    // Load has priority over step; step has priority over hold.
    always_comb begin
        if (load)      act = ACT_LOAD;
        else if (step) act = ACT_STEP;
        else           act = ACT_HOLD;
    end

    always_comb begin
        st_d = st_q;
        unique case (act)
            ACT_LOAD: begin
                st_d.start = start_in;
                st_d.beat  = '0;
            end
            ACT_STEP: st_d.beat = st_q.beat + CW'(1);
            default:  st_d = st_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign start_q = st_q.start;
    assign beat_q  = st_q.beat;
endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
    import burst_seq_pkg::*;
#(
    parameter int CW = 2
) (
    input  order_e        order,
    input  logic [CW-1:0] start,
    input  logic [CW-1:0] beat,
    output logic [CW-1:0] addr
);
    logic [CW-1:0] lin_addr;
    logic [CW-1:0] xor_addr;

    // Linear: modular add, carries out of the top bit dropped.
    assign lin_addr = start + beat;

    // Interleaved: bitwise flip of the start by the beat index.
    for (genvar b = 0; b < CW; b++) begin : g_xor_bit
        assign xor_addr[b] = start[b] ^ beat[b];
    end

    always_comb begin
        unique case (order)
            ORD_XOR: addr = xor_addr;
            default: addr = lin_addr;
        endcase
    end
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
    import burst_seq_pkg::*;
#(
    parameter int CW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          strobe_proc_n,
    input  logic          strobe_ctrl_n,
    input  logic          advance_n,
    input  logic          mode_interleave,
    input  logic [CW-1:0] start_lo,
    output logic [CW-1:0] addr_lo,
    output logic [CW-1:0] beat
);
    logic          load_req;
    logic          step_req;
    logic [CW-1:0] start_q;
    logic [CW-1:0] beat_q;
    order_e        order;

    assign load_req = ~strobe_proc_n | ~strobe_ctrl_n;
    assign step_req = ~advance_n;
    assign order    = mode_interleave ? ORD_XOR : ORD_LINEAR;

    burst_beat_ctrl #(.CW(CW)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load_req),
        .step     (step_req),
        .start_in (start_lo),
        .start_q  (start_q),
        .beat_q   (beat_q)
    );

    burst_order_map #(.CW(CW)) u_map (
        .order (order),
        .start (start_q),
        .beat  (beat_q),
        .addr  (addr_lo)
    );

    assign beat = beat_q;
endmodule

// File: rtl/burst_seq_checker.sv
module burst_seq_checker #(
    parameter int CW = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          strobe_proc_n,
    input logic          strobe_ctrl_n,
    input logic          advance_n,
    input logic          mode_interleave,
    input logic [CW-1:0] addr_lo,
    input logic [CW-1:0] beat
);
    logic no_strobe;
    assign no_strobe = strobe_proc_n && strobe_ctrl_n;

    // R2: any strobe restarts the beat index
    a_r2_load_clears_beat: assert property (@(posedge clk) disable iff (!rst_n)
        !no_strobe |=> beat == '0);

    // R7: strobe wins over a simultaneous advance
    a_r7_strobe_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (!no_strobe && !advance_n) |=> beat == '0);

    // R3: advance steps the beat by one
    a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
        (no_strobe && !advance_n) |=> beat == CW'($past(beat) + 1'b1));

    // R6: idle cycles hold the beat
    a_r6_hold_beat: assert property (@(posedge clk) disable iff (!rst_n)
        (no_strobe && advance_n) |=> $stable(beat));

    // R6: idle cycles hold the address while the order pin is steady
    a_r6_hold_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (no_strobe && advance_n) |=>
            (mode_interleave != $past(mode_interleave)) || $stable(addr_lo));

    // R4: linear order advances the address by one per beat
    a_r4_linear_step: assert property (@(posedge clk) disable iff (!rst_n)
        (no_strobe && !advance_n && !mode_interleave) |=>
            mode_interleave || (addr_lo == CW'($past(addr_lo) + 1'b1)));

    // R5: interleaved order keeps addr XOR beat constant within a burst
    a_r5_xor_invariant: assert property (@(posedge clk) disable iff (!rst_n)
        (no_strobe && !advance_n && mode_interleave) |=>
            !mode_interleave || ((addr_lo ^ beat) == $past(addr_lo ^ beat)));
endmodule

bind burst_addr_seq burst_seq_checker #(.CW(CW)) u_seq_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .strobe_proc_n   (strobe_proc_n),
    .strobe_ctrl_n   (strobe_ctrl_n),
    .advance_n       (advance_n),
    .mode_interleave (mode_interleave),
    .addr_lo         (addr_lo),
    .beat            (beat)
);

// File: tb/burst_addr_seq_bench.sv
module burst_addr_seq_bench;
    localparam int CW = 2;
    localparam int NV = 15;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          strobe_proc_n, strobe_ctrl_n, advance_n, mode_interleave;
    logic [CW-1:0] start_lo;
    logic [CW-1:0] addr_lo, beat;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    burst_addr_seq #(.CW(CW)) u_burst_addr_seq (
        .clk (clk), .rst_n (rst_n),
        .strobe_proc_n (strobe_proc_n), .strobe_ctrl_n (strobe_ctrl_n),
        .advance_n (advance_n), .mode_interleave (mode_interleave),
        .start_lo (start_lo), .addr_lo (addr_lo), .beat (beat)
    );

    // {sp_n, sc_n, adv_n, mode, start[1:0], exp_addr[1:0], exp_beat[1:0]}
    localparam logic [9:0] VEC [NV] = '{
        10'b0_1_1_0_01_01_00,  // 0  proc strobe, start 1
        10'b1_1_0_0_11_10_01,  // 1  linear step
        10'b1_1_0_0_00_11_10,  // 2
        10'b1_1_0_0_00_00_11,  // 3  wraps in group
        10'b1_1_0_0_00_01_00,  // 4  fourth advance back to start
        10'b1_1_1_0_10_01_00,  // 5  idle, start_lo ignored
        10'b1_0_1_1_10_10_00,  // 6  ctrl strobe, interleaved, start 2
        10'b1_1_0_1_00_11_01,  // 7
        10'b1_1_0_1_00_00_10,  // 8
        10'b1_1_0_1_00_01_11,  // 9
        10'b0_1_0_1_11_11_00,  // 10 strobe with advance
        10'b1_1_0_1_00_10_01,  // 11 3^1
        10'b1_1_1_0_01_00_01,  // 12 hold, mode flipped to linear: 3+1
        10'b0_0_1_0_00_00_00,  // 13 both strobes
        10'b1_1_0_0_10_01_01   // 14 step
    };

    function automatic string vec_req(int i);
        case (i)
            0, 6, 13: return "R2";
            1, 2, 3:  return "R4";
            4:        return "R8";
            5:        return "R9";
            7, 8, 9, 11: return "R5";
            10:       return "R7";
            12:       return "R6";
            default:  return "R3";
        endcase
    endfunction

    task automatic check(string req, logic [CW-1:0] a_exp, logic [CW-1:0] b_exp);
        n_checks++;
        if (addr_lo !== a_exp || beat !== b_exp) begin
            n_fails++;
            $display("FAIL %s: addr_lo=%0d beat=%0d expected addr_lo=%0d beat=%0d",
                     req, addr_lo, beat, a_exp, b_exp);
        end
    endtask

    task automatic drive(logic sp, logic sc, logic adv, logic md, logic [CW-1:0] st);
        strobe_proc_n = sp; strobe_ctrl_n = sc; advance_n = adv;
        mode_interleave = md; start_lo = st;
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        rst_n = 1'b0;
        strobe_proc_n = 1'b0; strobe_ctrl_n = 1'b1; advance_n = 1'b0;
        mode_interleave = 1'b0; start_lo = 2'd3;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", 2'd0, 2'd0);  // held in reset despite active strobe
        strobe_proc_n = 1'b1; advance_n = 1'b1;
        rst_n = 1'b1;
        @(posedge clk); @(negedge clk);
        check("R1", 2'd0, 2'd0);  // first cycle after reset

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i][9], VEC[i][8], VEC[i][7], VEC[i][6], VEC[i][5:4]);
            check(vec_req(i), VEC[i][3:2], VEC[i][1:0]);
        end

        // R6: long hold, start_lo toggling (R9)
        for (int k = 0; k < 4; k++) begin
            drive(1'b1, 1'b1, 1'b1, 1'b0, 2'(k));
            check("R6", 2'd1, 2'd1);
        end

        // R3 and R8: full interleaved burst from start 1
        drive(1'b1, 1'b0, 1'b1, 1'b1, 2'd1);
        check("R2", 2'd1, 2'd0);
        for (int k = 1; k <= 4; k++) begin
            drive(1'b1, 1'b1, 1'b0, 1'b1, 2'd0);
            check("R3", 2'(1 ^ (k % 4)), 2'(k % 4));
        end

        // R1: reset in mid burst
        drive(1'b1, 1'b1, 1'b0, 1'b1, 2'd0);
        rst_n = 1'b0;
        drive(1'b1, 1'b1, 1'b0, 1'b0, 2'd2);
        check("R1", 2'd0, 2'd0);
        rst_n = 1'b1;

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (2000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: run did not complete");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end
endmodule